// File: doc/BRIEF.md
# Flagged Shift/Add Arithmetic Unit

A purely combinational arithmetic unit that takes two 16-bit operands and a 3-bit command. It returns a 16-bit result and three status flags: zero, overflow and carry. It performs unsigned addition, signed addition, logical left shift and logical right shift. The two additions produce the same sum but give the overflow flag a different meaning. The shifts report the last bit moved out of the word through the carry flag.

The unit is meant to sit between operand selection and a register bank in a small datapath. The caller presents operands and a command, and reads the result and flags in the same cycle. Command codes that name no operation still drive every output to a fixed value.

Top module: `flag_alu`

## Requirements
- R1: With command 3'b000 (unsigned add), the result is (A + B) mod 2^16.
- R2: With command 3'b000, the carry flag is bit 16 of the 17-bit sum A + B, and the overflow flag equals the carry flag.
- R3: With command 3'b001 (signed add), the result is (A + B) mod 2^16. The carry flag is bit 16 of the 17-bit sum. The overflow flag is 1 exactly when A[15] equals B[15] and the result's bit 15 differs from them.
- R4: With command 3'b010 (logical left shift), the result is A shifted left by B[3:0] with zeros filled in. B[15:4] has no effect on any output.
- R5: With command 3'b011 (logical right shift), the result is A shifted right by B[3:0] with zeros filled in. B[15:4] has no effect on any output.
- R6: For both shifts, the overflow flag is 0. A shift amount of 0 returns A unchanged with carry 0. Any other shift amount puts the last bit shifted out in the carry flag: A[16-n] for a left shift by n, A[n-1] for a right shift by n.
- R7: Commands 3'b100 to 3'b111 give result 0, zero flag 1, overflow 0 and carry 0, whatever the operands are.
- R8: For every command, the zero flag is 1 exactly when the 16-bit result is 0.
- R9: The outputs follow the inputs with no clock or register in the path. They are valid in the same cycle that the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand; the value shifted for shift commands |
| b_i | input | 16 | Second operand; bits [3:0] give the shift amount |
| cmd_i | input | 3 | Operation select |
| res_o | output | 16 | Operation result |
| zero_o | output | 1 | Result equals zero |
| ovf_o | output | 1 | Overflow flag |
| carry_o | output | 1 | Carry out of the word, or last bit shifted out |

## Verification
Several flags can be raised by the same operation. A signed add of 0x8000 + 0x8000 sets carry, overflow and zero together. An unsigned add of 0xFFFF + 0x0001 sets carry and zero while the result wraps to 0. A left shift of 0x8000 by 1 sets carry with a zero result. The bench sends these corner operands, along with random ones, through every command code. Each output and flag is compared against an integer reference model half a cycle after the inputs change. For the shifts, operand B is also given nonzero upper bits, so that only B[3:0] should set the amount.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned CMD_W   = 3;
  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  typedef enum logic [CMD_W-1:0] {
    CMD_ADDU = 3'b000,
    CMD_ADDS = 3'b001,
    CMD_SLL  = 3'b010,
    CMD_SRL  = 3'b011
  } alu_cmd_e;
endpackage

// File: rtl/flag_alu_adder.sv
module flag_alu_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         sovf_o
);
  logic [W:0] sum_ext;

  assign sum_ext = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o   = sum_ext[W-1:0];
  assign carry_o = sum_ext[W];
  // two's complement overflow: like-signed operands, unlike-signed sum
  assign sovf_o  = (a_i[W-1] ~^ b_i[W-1]) & (sum_ext[W-1] ^ a_i[W-1]);

  always_comb begin
    // R3
    sovf_sign_chk: assert (!sovf_o || (a_i[W-1] == b_i[W-1]));
  end
endmodule

// File: rtl/flag_alu_shifter.sv
module flag_alu_shifter #(
  parameter int unsigned W    = 16,
  parameter bit          LEFT = 1'b1,
  localparam int unsigned SW  = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [SW-1:0] shamt_i,
  output logic [W-1:0]  res_o,
  output logic          carry_o
);
  logic [W:0] ext;

  // one guard bit beside the word catches the last bit moved out
  if (LEFT) begin : g_left
    assign ext     = {1'b0, a_i} << shamt_i;
    assign res_o   = ext[W-1:0];
    assign carry_o = ext[W];
  end else begin : g_right
    assign ext     = {a_i, 1'b0} >> shamt_i;
    assign res_o   = ext[W:1];
    assign carry_o = ext[0];
  end

  always_comb begin
    // R6
    zero_shift_chk: assert (shamt_i != '0 || (res_o == a_i && !carry_o));
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
(
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic [2:0]  cmd_i,
  output logic [15:0] res_o,
  output logic        zero_o,
  output logic        ovf_o,
  output logic        carry_o
);
  logic [DATA_W-1:0] add_sum, sll_res, srl_res;
  logic              add_c, add_sovf, sll_c, srl_c;

  flag_alu_adder #(.W(DATA_W)) u_add (
    .a_i(a_i), .b_i(b_i),
    .sum_o(add_sum), .carry_o(add_c), .sovf_o(add_sovf)
  );

  flag_alu_shifter #(.W(DATA_W), .LEFT(1'b1)) u_sll (
    .a_i(a_i), .shamt_i(b_i[SHAMT_W-1:0]),
    .res_o(sll_res), .carry_o(sll_c)
  );

  flag_alu_shifter #(.W(DATA_W), .LEFT(1'b0)) u_srl (
    .a_i(a_i), .shamt_i(b_i[SHAMT_W-1:0]),
    .res_o(srl_res), .carry_o(srl_c)
  );

  always_comb begin
    res_o   = '0;
    ovf_o   = 1'b0;
    carry_o = 1'b0;
    case (cmd_i)
      CMD_ADDU: begin res_o = add_sum; carry_o = add_c; ovf_o = add_c;    end
      CMD_ADDS: begin res_o = add_sum; carry_o = add_c; ovf_o = add_sovf; end
      CMD_SLL:  begin res_o = sll_res; carry_o = sll_c;                   end
      CMD_SRL:  begin res_o = srl_res; carry_o = srl_c;                   end
      default:  ;
    endcase
  end

  assign zero_o = (res_o == '0);

  always_comb begin
    // R2
    no_unsigned_ovf_mismatch_chk: assert (cmd_i != CMD_ADDU || ovf_o == carry_o);
    // R6
    no_overflow_chk: assert (!(cmd_i == CMD_SLL || cmd_i == CMD_SRL) || !ovf_o);
    // R7
    idle_code_chk: assert (!cmd_i[2] || (zero_o && !ovf_o && !carry_o && res_o == '0));
  end
endmodule

// File: tb/flag_alu_test.sv
`timescale 1ns/1ps
module flag_alu_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [15:0] a, b;
  logic [2:0]  cmd;
  logic [15:0] res;
  logic        zero, ovf, carry;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flag_alu uut (
    .a_i(a), .b_i(b), .cmd_i(cmd),
    .res_o(res), .zero_o(zero), .ovf_o(ovf), .carry_o(carry)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (a=%h b=%h cmd=%0d)",
               req, what, got, exp, a, b, cmd);
    end
  endtask

  // behavioural reference with plain integers
  task automatic compare();
    int ai = a, bi = b, n = b % 16, r = 0, c = 0, v = 0;
    string rr = "R7", cr = "R7";
    case (cmd)
      3'd0: begin r = (ai + bi) % 65536; c = (ai + bi) / 65536; v = c; rr = "R1"; cr = "R2"; end
      3'd1: begin
        int sa = (ai >= 32768) ? ai - 65536 : ai;
        int sb = (bi >= 32768) ? bi - 65536 : bi;
        r = (ai + bi) % 65536; c = (ai + bi) / 65536;
        v = (sa + sb > 32767 || sa + sb < -32768) ? 1 : 0;
        rr = "R3"; cr = "R3";
      end
      3'd2: begin r = (ai * (2 ** n)) % 65536; c = (n == 0) ? 0 : (ai / (2 ** (16 - n))) % 2; rr = "R4"; cr = "R6"; end
      3'd3: begin r = ai / (2 ** n); c = (n == 0) ? 0 : (ai / (2 ** (n - 1))) % 2; rr = "R5"; cr = "R6"; end
      default: ;
    endcase
    chk(rr, "result", int'(res), r);
    chk(cr, "carry", int'(carry), c);
    chk(cr, "overflow", int'(ovf), v);
    chk("R8", "zero", int'(zero), (r == 0) ? 1 : 0);
  endtask

  task automatic apply(input logic [15:0] av, input logic [15:0] bv, input logic [2:0] cv);
    @(posedge clk);
    a = av; b = bv; cmd = cv;
    @(negedge clk);
    compare();
  endtask

  initial begin
    logic [15:0] ops [12];
    ops = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234,
            16'h0010, 16'hFFF3, 16'h000F, 16'hA5A5, 16'h00F1, 16'h8001};
    a = '0; b = '0; cmd = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8", "reset-state zero", int'(zero), 1);
    chk("R1", "reset-state result", int'(res), 0);
    rst_ni = 1'b1;

    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          apply(ops[i], ops[j], 3'(c));

    // same-cycle response: change inputs mid-cycle, sample 1 ns later (R9)
    @(negedge clk);
    a = 16'hFFFF; b = 16'h0001; cmd = 3'd0;
    #1;
    chk("R9", "same-cycle result", int'(res), 0);
    chk("R9", "same-cycle carry", int'(carry), 1);

    for (int k = 0; k < 4000; k++)
      apply(16'($urandom), 16'($urandom), 3'($urandom));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule